// File: doc/BRIEF.md
# Prefix-Aware Instruction Byte Decoder

This block sits at the decode front end of a small 8-bit processor. It takes instruction bytes one at a time over a valid/ready handshake. It detects an optional leading prefix byte and then takes the opcode byte. It counts the operand bytes that the opcode calls for. When the last byte of an instruction has been taken, it emits a one-cycle completion pulse. The pulse carries the opcode, the prefix that was applied, the resulting addressing mode and the total length in bytes.

A prefix changes the meaning of the opcode that follows it. One prefix moves the index register from X to Y. One turns direct-style and byte-offset X-indexed modes into their memory-indirect forms. One turns byte-offset X-indexed addressing into indirect Y-indexed addressing. An opcode-position byte that is neither a legal opcode nor a prefix raises a one-cycle reset request. A prefix/opcode pair that simply does not make sense raises no reset. It is reported as unsupported instead. The set of illegal codes is a 256-bit parameter.

Top module: `pfx_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `instr_done` and `rst_req` are 0 and `in_ready` is 1. A reset in the middle of an instruction discards any prefix already taken, so the next byte is handled as the first byte of a new instruction.
- R2: The prefix codes are 0x90 (Y swap, reported as `instr_prefix` = 1), 0x92 (make indirect, reported as 2) and 0x91 (indirect Y, reported as 3). An instruction with no prefix reports 0. A prefix taken in first position produces no pulse of its own, and it never raises `rst_req`.
- R3: The high nibble of the opcode selects a family code (bits [3:0] of `instr_mode`) and an operand count. The pairs are: 0 → 9 (bit-test relative), 2 bytes; 1 → 8 (bit op), 1; 2 → 7 (relative), 1; 3 and B → 2 (direct), 1; 4, 5, 8 and 9 → 0 (inherent), 0; A → 1 (immediate), 1; C → 3 (extended), 2; D → 6 (X + 16-bit offset), 2; 6 and E → 5 (X + 8-bit offset), 1; 7 and F → 4 (X, no offset), 0. An opcode refers to X when its row is 5, 6, 7, D, E or F, or when its row is A, B or C and its low nibble is E or F. `instr_mode` is {indirect, use_y, family}.
- R4: With the default map, an opcode whose high nibble is 3 to 8 and whose low nibble is 2 or 5 is illegal. Taking such a byte raises `rst_req` in the next cycle and gives no `instr_done`.
- R5: `instr_len` equals (1 if a prefix was used) + 1 + the operand count. `instr_done` is high for exactly the one cycle after the final byte of the instruction is taken, and the fields are valid in that cycle.
- R6: Prefix 0x90 on an opcode that refers to X sets use_y (bit 4) and leaves indirect clear.
- R7: Prefix 0x92 on family 2, 5, 7, 8 or 9 sets indirect (bit 5) and leaves use_y clear.
- R8: Prefix 0x91 on family 5 sets both indirect and use_y.
- R9: A legal prefix followed by a legal opcode that the prefix does not apply to sets `instr_unsup`. The mode keeps the unmodified family with bits 5:4 clear, the length is still computed, and no `rst_req` is raised.
- R10: A prefix byte in opcode position, after a prefix, completes a 2-byte instruction. That instruction carries the byte as its opcode, the first prefix, mode 0 and `instr_unsup` = 1, with no `rst_req`. The decoder then waits for a new first byte.
- R11: An illegal opcode after a prefix also raises `rst_req`. `rst_req` is always a one-cycle pulse, and `in_ready` is 0 in that cycle. Afterwards the decoder is idle with no prefix held.
- R12: Cycles with `in_valid` low change nothing, whatever value `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An instruction byte is offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | The decoder takes a byte this cycle if one is offered |
| instr_done | output | 1 | One-cycle pulse: an instruction has completed |
| instr_opcode | output | 8 | Opcode byte of the completed instruction |
| instr_prefix | output | 2 | Prefix applied: 0 none, 1 = 0x90, 2 = 0x92, 3 = 0x91 |
| instr_mode | output | 6 | {indirect, use_y, family[3:0]} |
| instr_len | output | 3 | Total instruction length in bytes (1 to 4) |
| instr_unsup | output | 1 | The prefix and opcode form an unsupported pair |
| rst_req | output | 1 | One-cycle request for a system reset on an illegal code |

## Verification
The assertions assume that `in_valid` and `in_data` carry known values whenever reset is released. They also assume that the byte stream starts on an instruction boundary after each reset. The bench always drives defined values, and it drives arbitrary non-illegal or illegal junk on `in_data` while `in_valid` is low. It changes inputs only on the falling clock edge. After a reset it starts every sequence at a fresh instruction. In the random phase, every byte is fed to the bench's own model, so the model and the design stay aligned on instruction boundaries.

// File: rtl/pfxd_pkg.sv
package pfxd_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_CODES = 1 << BYTE_W;
  localparam int LEN_W     = 3;
  localparam int FAM_W     = 4;
  localparam int MODE_W    = FAM_W + 2;
  localparam int NOPS_W    = 2;

  typedef enum logic [FAM_W-1:0] {
    FAM_INH   = 4'd0,
    FAM_IMM   = 4'd1,
    FAM_DIR   = 4'd2,
    FAM_EXT   = 4'd3,
    FAM_IDX0  = 4'd4,
    FAM_IDX8  = 4'd5,
    FAM_IDX16 = 4'd6,
    FAM_REL   = 4'd7,
    FAM_DBIT  = 4'd8,
    FAM_DBREL = 4'd9
  } fam_e;

  typedef enum logic [1:0] {
    PFX_NONE  = 2'd0,
    PFX_YSWAP = 2'd1,
    PFX_IND   = 2'd2,
    PFX_YIND  = 2'd3
  } pfx_e;

  typedef struct packed {
    logic              legal;
    fam_e              fam;
    logic [NOPS_W-1:0] nops;
    logic              xref;
  } op_info_t;

  // Default illegal-code map: rows 3..8, columns 2 and 5.
  function automatic logic [NUM_CODES-1:0] default_illegal_map();
    logic [NUM_CODES-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if ((i / 16) >= 3 && (i / 16) <= 8 && ((i % 16) == 2 || (i % 16) == 5))
        m[i] = 1'b1;
    end
    return m;
  endfunction

  // Row-based family, operand count and X-reference flag.
  function automatic op_info_t decode_row(logic [BYTE_W-1:0] b);
    op_info_t r;
    r.legal = 1'b0;
    r.xref  = 1'b0;
    r.nops  = 2'd0;
    r.fam   = FAM_INH;
    unique case (b[7:4])
      4'h0: begin r.fam = FAM_DBREL; r.nops = 2'd2; end
      4'h1: begin r.fam = FAM_DBIT;  r.nops = 2'd1; end
      4'h2: begin r.fam = FAM_REL;   r.nops = 2'd1; end
      4'h3: begin r.fam = FAM_DIR;   r.nops = 2'd1; end
      4'h4: begin r.fam = FAM_INH;   r.nops = 2'd0; end
      4'h5: begin r.fam = FAM_INH;   r.nops = 2'd0; r.xref = 1'b1; end
      4'h6: begin r.fam = FAM_IDX8;  r.nops = 2'd1; r.xref = 1'b1; end
      4'h7: begin r.fam = FAM_IDX0;  r.nops = 2'd0; r.xref = 1'b1; end
      4'h8: begin r.fam = FAM_INH;   r.nops = 2'd0; end
      4'h9: begin r.fam = FAM_INH;   r.nops = 2'd0; end
      4'hA: begin r.fam = FAM_IMM;   r.nops = 2'd1; r.xref = (b[3:1] == 3'b111); end
      4'hB: begin r.fam = FAM_DIR;   r.nops = 2'd1; r.xref = (b[3:1] == 3'b111); end
      4'hC: begin r.fam = FAM_EXT;   r.nops = 2'd2; r.xref = (b[3:1] == 3'b111); end
      4'hD: begin r.fam = FAM_IDX16; r.nops = 2'd2; r.xref = 1'b1; end
      4'hE: begin r.fam = FAM_IDX8;  r.nops = 2'd1; r.xref = 1'b1; end
      default: begin r.fam = FAM_IDX0; r.nops = 2'd0; r.xref = 1'b1; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfxd_classify.sv
module pfxd_classify
  import pfxd_pkg::*;
#(
  parameter logic [NUM_CODES-1:0] ILLEGAL_MAP = default_illegal_map(),
  parameter logic [BYTE_W-1:0]    CODE_YSWAP  = 8'h90,
  parameter logic [BYTE_W-1:0]    CODE_IND    = 8'h92,
  parameter logic [BYTE_W-1:0]    CODE_YIND   = 8'h91
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_pfx_o,
  output pfx_e              kind_o,
  output op_info_t          info_o
);

  localparam int NUM_PFX = 3;
  // Slot k maps to prefix kind k+1.
  localparam logic [NUM_PFX*BYTE_W-1:0] CODE_TAB = {CODE_YIND, CODE_IND, CODE_YSWAP};

  logic [NUM_PFX-1:0] hit;

  for (genvar g = 0; g < NUM_PFX; g++) begin : g_match
    assign hit[g] = (byte_i == CODE_TAB[g*BYTE_W +: BYTE_W]);
  end

  always_comb begin
    is_pfx_o = |hit;
    kind_o   = PFX_NONE;
    for (int k = 0; k < NUM_PFX; k++) begin
      if (hit[k]) kind_o = pfx_e'(2'(k + 1));
    end
    info_o       = decode_row(byte_i);
    info_o.legal = !ILLEGAL_MAP[byte_i] && !is_pfx_o;
  end

endmodule

// File: rtl/pfxd_modify.sv
module pfxd_modify
  import pfxd_pkg::*;
(
  input  pfx_e              pfx_i,
  input  fam_e              fam_i,
  input  logic              xref_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              unsup_o
);

  logic ind;
  logic use_y;

  always_comb begin
    ind     = 1'b0;
    use_y   = 1'b0;
    unsup_o = 1'b0;
    unique case (pfx_i)
      PFX_NONE: ;
      PFX_YSWAP: begin
        if (xref_i) use_y   = 1'b1;
        else        unsup_o = 1'b1;
      end
      PFX_IND: begin
        if (fam_i inside {FAM_DIR, FAM_DBIT, FAM_DBREL, FAM_REL, FAM_IDX8}) ind = 1'b1;
        else unsup_o = 1'b1;
      end
      default: begin
        if (fam_i == FAM_IDX8) begin
          ind   = 1'b1;
          use_y = 1'b1;
        end else begin
          unsup_o = 1'b1;
        end
      end
    endcase
    mode_o = {ind, use_y, fam_i};
  end

endmodule

// File: rtl/pfxd_seq.sv
module pfxd_seq
  import pfxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              is_pfx_i,
  input  pfx_e              kind_i,
  input  logic              legal_i,
  input  logic [NOPS_W-1:0] nops_i,
  input  logic [MODE_W-1:0] mod_mode_i,
  input  logic              mod_unsup_i,
  output pfx_e              pfx_cur_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [BYTE_W-1:0] opc_o,
  output pfx_e              pfx_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              unsup_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_OPC, ST_OPER} st_e;

  st_e               st_q, st_d;
  pfx_e              pfx_q, pfx_d;
  logic [NOPS_W-1:0] left_q, left_d;
  logic [BYTE_W-1:0] opc_q, opc_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              unsup_q, unsup_d;
  logic              done_q, done_d;
  logic              trap_q, trap_d;
  logic              accept;
  logic [LEN_W-1:0]  head_len;

  assign in_ready  = !trap_q;
  assign accept    = in_valid && in_ready;
  assign pfx_cur_o = (st_q == ST_OPC) ? pfx_q : PFX_NONE;
  assign head_len  = (st_q == ST_OPC) ? LEN_W'(2) : LEN_W'(1);

  always_comb begin
    st_d    = st_q;
    pfx_d   = pfx_q;
    left_d  = left_q;
    opc_d   = opc_q;
    mode_d  = mode_q;
    len_d   = len_q;
    unsup_d = unsup_q;
    done_d  = 1'b0;
    trap_d  = 1'b0;
    if (accept) begin
      if (st_q == ST_OPER) begin
        left_d = left_q - NOPS_W'(1);
        if (left_q == NOPS_W'(1)) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end else if (is_pfx_i && st_q == ST_IDLE) begin
        pfx_d = kind_i;
        st_d  = ST_OPC;
      end else if (is_pfx_i) begin
        opc_d   = in_data;
        mode_d  = {2'b00, FAM_INH};
        unsup_d = 1'b1;
        len_d   = LEN_W'(2);
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end else if (!legal_i) begin
        trap_d = 1'b1;
        pfx_d  = PFX_NONE;
        st_d   = ST_IDLE;
      end else begin
        if (st_q == ST_IDLE) pfx_d = PFX_NONE;
        opc_d   = in_data;
        mode_d  = mod_mode_i;
        unsup_d = mod_unsup_i;
        len_d   = head_len + LEN_W'(nops_i);
        if (nops_i == '0) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          left_d = nops_i;
          st_d   = ST_OPER;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pfx_q  <= PFX_NONE;
      left_q <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pfx_q  <= pfx_d;
      left_q <= left_d;
      done_q <= done_d;
      trap_q <= trap_d;
    end
  end

  // Instruction fields, loaded only when a byte is taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q   <= '0;
      mode_q  <= '0;
      len_q   <= '0;
      unsup_q <= 1'b0;
    end else if (accept) begin
      opc_q   <= opc_d;
      mode_q  <= mode_d;
      len_q   <= len_d;
      unsup_q <= unsup_d;
    end
  end

  assign done_o  = done_q;
  assign trap_o  = trap_q;
  assign opc_o   = opc_q;
  assign pfx_o   = pfx_q;
  assign mode_o  = mode_q;
  assign len_o   = len_q;
  assign unsup_o = unsup_q;

  p_trap_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |=> !trap_q);
  p_trap_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> !in_ready);
  p_trap_no_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> !done_q);
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (len_q >= LEN_W'(1) && len_q <= LEN_W'(4)));
  p_pfx_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && pfx_q != PFX_NONE) |-> len_q >= LEN_W'(2));
  p_unsup_pfx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && unsup_q) |-> pfx_q != PFX_NONE);
  p_ind_pfx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q[MODE_W-1]) |-> (pfx_q == PFX_IND || pfx_q == PFX_YIND));
  p_oper_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_OPER |-> left_q != '0);
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(st_q) && $stable(left_q) && !done_q && !trap_q));

endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
  import pfxd_pkg::*;
#(
  parameter logic [NUM_CODES-1:0] ILLEGAL_MAP = default_illegal_map(),
  parameter logic [BYTE_W-1:0]    CODE_YSWAP  = 8'h90,
  parameter logic [BYTE_W-1:0]    CODE_IND    = 8'h92,
  parameter logic [BYTE_W-1:0]    CODE_YIND   = 8'h91
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        instr_done,
  output logic [7:0]  instr_opcode,
  output logic [1:0]  instr_prefix,
  output logic [5:0]  instr_mode,
  output logic [2:0]  instr_len,
  output logic        instr_unsup,
  output logic        rst_req
);

  logic              is_pfx;
  pfx_e              kind;
  op_info_t          info;
  pfx_e              pfx_cur;
  pfx_e              pfx_out;
  logic [MODE_W-1:0] mod_mode;
  logic              mod_unsup;

  pfxd_classify #(
    .ILLEGAL_MAP (ILLEGAL_MAP),
    .CODE_YSWAP  (CODE_YSWAP),
    .CODE_IND    (CODE_IND),
    .CODE_YIND   (CODE_YIND)
  ) u_classify (
    .byte_i   (in_data),
    .is_pfx_o (is_pfx),
    .kind_o   (kind),
    .info_o   (info)
  );

  pfxd_modify u_modify (
    .pfx_i   (pfx_cur),
    .fam_i   (info.fam),
    .xref_i  (info.xref),
    .mode_o  (mod_mode),
    .unsup_o (mod_unsup)
  );

  pfxd_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .is_pfx_i    (is_pfx),
    .kind_i      (kind),
    .legal_i     (info.legal),
    .nops_i      (info.nops),
    .mod_mode_i  (mod_mode),
    .mod_unsup_i (mod_unsup),
    .pfx_cur_o   (pfx_cur),
    .done_o      (instr_done),
    .trap_o      (rst_req),
    .opc_o       (instr_opcode),
    .pfx_o       (pfx_out),
    .mode_o      (instr_mode),
    .len_o       (instr_len),
    .unsup_o     (instr_unsup)
  );

  assign instr_prefix = pfx_out;

endmodule

// File: tb/pfx_decoder_bench.sv
module pfx_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       instr_done;
  logic [7:0] instr_opcode;
  logic [1:0] instr_prefix;
  logic [5:0] instr_mode;
  logic [2:0] instr_len;
  logic       instr_unsup;
  logic       rst_req;

  pfx_decoder u_pfx_decoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_ready     (in_ready),
    .instr_done   (instr_done),
    .instr_opcode (instr_opcode),
    .instr_prefix (instr_prefix),
    .instr_mode   (instr_mode),
    .instr_len    (instr_len),
    .instr_unsup  (instr_unsup),
    .rst_req      (rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_chk = 0;
  int    n_err = 0;
  bit    run_chk = 0;
  bit    ended = 0;
  string phase = "R1";

  // Reference model state (behavioural).
  int    m_state, m_pfx, m_left;
  bit    exp_done, exp_trap, exp_ready;
  int    e_opc, e_pfx, e_mode, e_len, e_bad;
  string e_tag, t_tag;
  int    b, pk, f, n, ind, yy, bd;
  bit    fin, nt;

  function automatic int pcode(int v);
    if (v == 'h90) return 1;
    if (v == 'h92) return 2;
    if (v == 'h91) return 3;
    return 0;
  endfunction

  function automatic bit illegal(int v);
    int r = v / 16;
    int c = v % 16;
    return (r >= 3 && r <= 8 && (c == 2 || c == 5));
  endfunction

  function automatic int fam_of(int v);
    case (v / 16)
      0: return 9;  1: return 8;  2: return 7;  3: return 2;
      6: return 5;  7: return 4;  10: return 1; 11: return 2;
      12: return 3; 13: return 6; 14: return 5; 15: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int nops_of(int v);
    case (v / 16)
      0, 12, 13: return 2;
      1, 2, 3, 6, 10, 11, 14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit xref_of(int v);
    int r = v / 16;
    if (r == 5 || r == 6 || r == 7 || r >= 13) return 1;
    if (r >= 10 && r <= 12 && (v % 16) >= 14) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_pfx = 0; m_left = 0;
      exp_done = 0; exp_trap = 0; exp_ready = 1;
      t_tag = "R4";
    end else begin
      fin = 0;
      nt  = 0;
      if (in_valid && exp_ready) begin
        b  = int'(in_data);
        pk = pcode(b);
        if (m_state == 2) begin
          m_left--;
          if (m_left == 0) begin fin = 1; m_state = 0; end
        end else if (pk != 0 && m_state == 0) begin
          m_pfx   = pk;
          m_state = 1;
        end else if (pk != 0) begin
          e_opc = b; e_pfx = m_pfx; e_mode = 0; e_len = 2; e_bad = 1;
          e_tag = "R10"; fin = 1; m_state = 0;
        end else if (illegal(b)) begin
          nt = 1;
          t_tag = (m_state == 1) ? "R11" : "R4";
          m_state = 0; m_pfx = 0;
        end else begin
          if (m_state == 0) m_pfx = 0;
          f = fam_of(b); n = nops_of(b);
          ind = 0; yy = 0; bd = 0;
          if (m_pfx == 1) begin
            if (xref_of(b)) yy = 1; else bd = 1;
          end else if (m_pfx == 2) begin
            if (f == 2 || f == 5 || f == 7 || f == 8 || f == 9) ind = 1; else bd = 1;
          end else if (m_pfx == 3) begin
            if (f == 5) begin ind = 1; yy = 1; end else bd = 1;
          end
          e_opc = b; e_pfx = m_pfx; e_mode = ind * 32 + yy * 16 + f; e_bad = bd;
          e_len = ((m_state == 1) ? 2 : 1) + n;
          if (bd) e_tag = "R9";
          else if (m_pfx == 1) e_tag = "R6";
          else if (m_pfx == 2) e_tag = "R7";
          else if (m_pfx == 3) e_tag = "R8";
          else e_tag = "R3";
          if (n == 0) begin fin = 1; m_state = 0; end
          else begin m_left = n; m_state = 2; end
        end
      end
      exp_done  = fin;
      exp_trap  = nt;
      exp_ready = !nt;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s (phase %s) at %0t: actual %0h expected %0h", req, phase, $time, act, exp);
    end
  endtask

  // Per-cycle comparison with the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && run_chk && !ended) begin
      check("R11", 32'(in_ready), 32'(exp_ready));
      check(t_tag, 32'(rst_req), 32'(exp_trap));
      check("R5", 32'(instr_done), 32'(exp_done));
      if (exp_done) begin
        check("R3", 32'(instr_opcode), 32'(e_opc));
        check("R2", 32'(instr_prefix), 32'(e_pfx));
        check(e_tag, 32'(instr_mode), 32'(e_mode));
        check("R5", 32'(instr_len), 32'(e_len));
        check(e_tag, 32'(instr_unsup), 32'(e_bad));
      end
    end
  end

  task automatic finish_run();
    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic send(input logic [7:0] v);
    @(negedge clk);
    while (!in_ready) begin
      in_valid = 0;
      @(negedge clk);
    end
    in_valid = 1;
    in_data  = v;
  endtask

  task automatic gap(input int cycles, input logic [7:0] junk);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 0;
      in_data  = junk;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      n_err++;
      $display("FAIL watchdog (phase %s): run did not end", phase);
      finish_run();
    end
  end

  initial begin
    in_valid = 0;
    in_data  = 8'h00;
    rst_n    = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs while reset is held
    check("R1", 32'(instr_done), 0);
    check("R1", 32'(rst_req), 0);
    check("R1", 32'(in_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'(instr_done), 0);
    check("R1", 32'(rst_req), 0);
    check("R1", 32'(in_ready), 1);
    run_chk = 1;

    phase = "R3";
    send(8'h4A);
    send(8'hA6); send(8'h12);
    send(8'hC6); send(8'h10); send(8'h20);
    send(8'h0A); send(8'h40); send(8'h05);
    send(8'h15); send(8'h33);
    send(8'h27); send(8'hFE);
    send(8'hD6); send(8'h01); send(8'h02);
    send(8'hF6);
    send(8'h5C);
    gap(2, 8'h00);

    phase = "R6";
    send(8'h90); send(8'hFE);
    send(8'h90); send(8'hAE); send(8'h05);
    send(8'h90); send(8'hD7); send(8'h10); send(8'h00);
    send(8'h90); send(8'h5C);
    gap(1, 8'h00);

    phase = "R7";
    send(8'h92); send(8'h3C); send(8'h80);
    send(8'h92); send(8'hE6); send(8'h40);
    send(8'h92); send(8'h17); send(8'h20);
    send(8'h92); send(8'h0C); send(8'h20); send(8'h07);
    send(8'h92); send(8'h27); send(8'h10);
    gap(1, 8'h00);

    phase = "R8";
    send(8'h91); send(8'hE6); send(8'h40);
    send(8'h91); send(8'hEE); send(8'h10);
    gap(1, 8'h00);

    phase = "R9";
    send(8'h90); send(8'hA6); send(8'h01);
    send(8'h92); send(8'hC6); send(8'h10); send(8'h00);
    send(8'h91); send(8'hF6);
    send(8'h91); send(8'h3C); send(8'h11);
    gap(1, 8'h00);

    phase = "R10";
    send(8'h90); send(8'h92);
    send(8'hA6); send(8'h01);
    send(8'h91); send(8'h91);
    gap(1, 8'h00);

    phase = "R4";
    send(8'h35);
    send(8'h82);
    send(8'h4A);
    gap(2, 8'h00);

    phase = "R11";
    send(8'h92); send(8'h42);
    send(8'hA6); send(8'h55);
    send(8'h90); send(8'h85);
    send(8'h4A);
    gap(2, 8'h00);

    // R12: junk on in_data, including illegal and prefix codes, while in_valid is low
    phase = "R12";
    send(8'hC6); gap(3, 8'h35); send(8'h10); gap(2, 8'h92); send(8'h20);
    gap(2, 8'h75);
    send(8'h4A);
    gap(1, 8'h00);

    // R1: a reset taken after a prefix leaves no prefix behind
    phase = "R1";
    send(8'h92);
    @(negedge clk);
    in_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    send(8'hB6); send(8'h10);
    gap(2, 8'h00);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(3) == 0) gap(1, 8'($urandom_range(255)));
      else send(8'($urandom_range(255)));
    end
    gap(6, 8'h00);

    finish_run();
  end

endmodule